// File: doc/BRIEF.md
# Serial Slave Command Front End with Pause

This block is the serial front end of a small register device with four channels. It runs on the chip's system clock and oversamples the serial pins (SCK, chip select, SI, pause, write protect) through synchronizers. It finds SCK edges and decodes each transfer into a simple parallel command for the register file next to it. A transfer opens with an addressing byte, continues with an instruction byte, and ends with one data byte. On a write the host sends that data byte. On a read the device returns it on SO. Up to four devices share one bus, and each is told apart by two strap inputs.

The host may pause a transfer at any point with an active-low pause input. The bit position and the partial byte are frozen, SO is released, and the transfer carries on from the same bit once the pause is lifted. A write-protect input blocks the nonvolatile form of the write command. After reset the block stays silent until it has seen chip select fall once.

Top module: `spi_fe_top`

## Requirements
- R1: SI is sampled on rising SCK, most significant bit first. The first byte of a transfer must have bits 7..2 equal to 010100 and bits 1..0 equal to `strap`. If it does not, the rest of the transfer is ignored: no write strobe, no read request, and `so_oe` stays low.
- R2: After reset, the block accepts nothing until `cs_n` has gone from high to low. A transfer sent while `cs_n` has been low ever since reset produces no strobe and no read request.
- R3: While `cs_n` is high, `so_oe` is low and the serial state returns to the start of a transfer. If `cs_n` rises inside a byte, the partial byte is discarded and no strobe is issued.
- R4: The instruction byte holds the operation in bits 7..4 and the channel in bits 1..0. The operations are 1001 (read), 1010 (volatile write) and 1100 (nonvolatile write). If bits 3..2 are not zero, or the operation is any other code, the rest of the transfer is ignored.
- R5: For a write, the third byte carries the value in bits 5..0 and must have bits 7..6 equal to zero. After its eighth rising SCK edge, `wr_stb` pulses for exactly one clock with `wr_chan`, `wr_data`, and `wr_nv` (1 for the nonvolatile write). If bits 7..6 are not zero, or on any byte after the third, no strobe is issued.
- R6: While `wp_n` is low, a nonvolatile write issues no strobe. A volatile write is not affected.
- R7: For a read, `rd_req` pulses for one clock with `rd_chan` after the instruction byte, and `rd_data` is taken on the following clock. The device then sends {00, rd_data} MSB first. SO changes on falling SCK, and the first bit appears at the first falling edge after the instruction byte. `so_oe` is high only during that returned byte.
- R8: `hold_n` going low while SCK is low pauses the transfer. SCK edges are then ignored, the bit position and partial byte are kept, and `so_oe` is low. `hold_n` going high while SCK is low resumes the transfer at the same bit.
- R9: A change of `hold_n` made while SCK is high takes effect only once SCK is low. The falling edge that ends that high phase is still handled under the pause state that held before it.

SCK high and low phases must each last at least 8 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect for nonvolatile writes |
| strap | input | 2 | Device address straps |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO (low means high impedance) |
| wr_stb | output | 1 | One-cycle write command strobe |
| wr_chan | output | 2 | Channel of the write |
| wr_data | output | 6 | Value to write |
| wr_nv | output | 1 | Write is nonvolatile |
| rd_req | output | 1 | One-cycle read request |
| rd_chan | output | 2 | Channel to read |
| rd_data | input | 6 | Read value, valid the clock after rd_req |

## Verification
The hardest cases to reach are the pause changes made while SCK is high in the middle of a returned byte. In these cases the only visible effect is whether one particular falling edge advances SO. The stimulus builds these cases on purpose. In one, the pause drops just after a rising edge, so the next falling edge must still shift SO. In the other, the pause lifts while SCK is high, so the following falling edge must not shift SO. In both, the next sampled bit tells the two behaviours apart. Random transfers mix these pause shapes with every byte and bit position, write-protect levels and address mismatches.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;

  typedef enum logic [2:0] {
    PH_ADDR,
    PH_INSTR,
    PH_WDATA,
    PH_READ,
    PH_SKIP
  } phase_e;

  localparam logic [OP_W-1:0] OP_RD  = 4'b1001;
  localparam logic [OP_W-1:0] OP_WV  = 4'b1010;
  localparam logic [OP_W-1:0] OP_WNV = 4'b1100;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic held
);
  logic held_q, held_d;

  // pause state may only change while the serial clock is low
  always_comb begin
    held_d = held_q;
    if (!cs_act)     held_d = 1'b0;
    else if (!sck_s) held_d = ~hold_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign held = held_q;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  rise_en,
  input  logic                  si_s,
  output logic                  byte_vld,
  output logic [BW-1:0]         byte_q,
  output logic [$clog2(BW)-1:0] bit_cnt
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW-1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] sh_q, sh_d, byt_q, byt_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    byt_d = byt_q;
    vld_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (rise_en) begin
      sh_d = {sh_q[BW-2:0], si_s};
      if (cnt_q == LAST) begin
        cnt_d = '0;
        vld_d = 1'b1;
        byt_d = {sh_q[BW-2:0], si_s};
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      byt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      byt_q <= byt_d;
      vld_q <= vld_d;
    end
  end

  assign byte_vld = vld_q;
  assign byte_q   = byt_q;
  assign bit_cnt  = cnt_q;
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  input  logic          shift,
  output logic          so
);
  logic [BW-1:0] sr_q, sr_d;
  logic          so_q, so_d;

  always_comb begin
    sr_d = sr_q;
    so_d = so_q;
    if (load) begin
      sr_d = load_val;
    end else if (shift) begin
      so_d = sr_q[BW-1];
      sr_d = {sr_q[BW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      so_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      so_q <= so_d;
    end
  end

  assign so = so_q;
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int CHW = 2,
  parameter int DW = 6,
  parameter int STRAP_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-STRAP_W-1:0] ADDR_HI = 6'b010100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck,
  input  logic           cs_n,
  input  logic           si,
  input  logic           hold_n,
  input  logic           wp_n,
  input  logic [STRAP_W-1:0] strap,
  output logic           so,
  output logic           so_oe,
  output logic           wr_stb,
  output logic [CHW-1:0] wr_chan,
  output logic [DW-1:0]  wr_data,
  output logic           wr_nv,
  output logic           rd_req,
  output logic [CHW-1:0] rd_chan,
  input  logic [DW-1:0]  rd_data
);
  localparam int CW = $clog2(BYTE_W);
  localparam int NSYNC = 5;
  // sync order: {wp_n, hold_n, si, cs_n, sck}
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b01000;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [NSYNC-1:0] pins_s;
  logic sck_s, cs_n_s, si_s, hold_n_s, wp_n_s;

  spi_fe_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_ni),
    .d({wp_n, hold_n, si, cs_n, sck}),
    .q(pins_s)
  );
  assign {wp_n_s, hold_n_s, si_s, cs_n_s, sck_s} = pins_s;

  logic sck_prev_q, cs_n_prev_q, armed_q, armed_d;
  logic cs_act, held, en, sck_rise, sck_fall, clr;

  assign cs_act   = ~cs_n_s;
  assign armed_d  = armed_q | (cs_n_prev_q & ~cs_n_s);
  assign en       = armed_q & cs_act & ~held;
  assign sck_rise = en & sck_s & ~sck_prev_q;
  assign sck_fall = en & ~sck_s & sck_prev_q;
  assign clr      = ~cs_act | ~armed_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q  <= 1'b0;
      cs_n_prev_q <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      sck_prev_q  <= sck_s;
      cs_n_prev_q <= cs_n_s;
      armed_q     <= armed_d;
    end
  end

  spi_fe_hold u_hold (
    .clk(clk), .rst_n(rst_ni), .cs_act(cs_act),
    .sck_s(sck_s), .hold_n_s(hold_n_s), .held(held)
  );

  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;
  logic [CW-1:0]     bit_cnt;

  spi_fe_rx #(.BW(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_ni), .clr(clr), .rise_en(sck_rise), .si_s(si_s),
    .byte_vld(byte_vld), .byte_q(byte_q), .bit_cnt(bit_cnt)
  );

  phase_e            ph_q, ph_d;
  logic [CHW-1:0]    wchan_q, wchan_d, wrchan_q, wrchan_d, rchan_q, rchan_d;
  logic              wnv_q, wnv_d, wrnv_q, wrnv_d;
  logic              stb_q, stb_d, rdreq_q, rdreq_d, ld_q, oe_q, oe_d;
  logic [DW-1:0]     wdata_q, wdata_d;
  logic [OP_W-1:0]   op;
  logic              resv_ok, data_ok;

  assign op      = byte_q[BYTE_W-1 -: OP_W];
  assign resv_ok = (byte_q[BYTE_W-OP_W-1:CHW] == '0);
  assign data_ok = (byte_q[BYTE_W-1:DW] == '0);

  always_comb begin
    ph_d     = ph_q;
    wchan_d  = wchan_q;
    wnv_d    = wnv_q;
    wrchan_d = wrchan_q;
    wrnv_d   = wrnv_q;
    wdata_d  = wdata_q;
    rchan_d  = rchan_q;
    stb_d    = 1'b0;
    rdreq_d  = 1'b0;
    if (clr) begin
      ph_d = PH_ADDR;
    end else if (byte_vld) begin
      unique case (ph_q)
        PH_ADDR: begin
          ph_d = (byte_q == {ADDR_HI, strap}) ? PH_INSTR : PH_SKIP;
        end
        PH_INSTR: begin
          ph_d = PH_SKIP;
          if (resv_ok) begin
            if (op == OP_RD) begin
              ph_d    = PH_READ;
              rdreq_d = 1'b1;
              rchan_d = byte_q[CHW-1:0];
            end else if (op == OP_WV || op == OP_WNV) begin
              ph_d    = PH_WDATA;
              wchan_d = byte_q[CHW-1:0];
              wnv_d   = (op == OP_WNV);
            end
          end
        end
        PH_WDATA: begin
          ph_d = PH_SKIP;
          if (data_ok && (!wnv_q || wp_n_s)) begin
            stb_d    = 1'b1;
            wdata_d  = byte_q[DW-1:0];
            wrchan_d = wchan_q;
            wrnv_d   = wnv_q;
          end
        end
        default: ph_d = PH_SKIP;
      endcase
    end
  end

  assign oe_d = en & (ph_q == PH_READ);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_ADDR;
      wchan_q  <= '0;
      wnv_q    <= 1'b0;
      wrchan_q <= '0;
      wrnv_q   <= 1'b0;
      wdata_q  <= '0;
      rchan_q  <= '0;
      stb_q    <= 1'b0;
      rdreq_q  <= 1'b0;
      ld_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      wchan_q  <= wchan_d;
      wnv_q    <= wnv_d;
      wrchan_q <= wrchan_d;
      wrnv_q   <= wrnv_d;
      wdata_q  <= wdata_d;
      rchan_q  <= rchan_d;
      stb_q    <= stb_d;
      rdreq_q  <= rdreq_d;
      ld_q     <= rdreq_q;
      oe_q     <= oe_d;
    end
  end

  spi_fe_tx #(.BW(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_ni), .load(ld_q),
    .load_val({{(BYTE_W-DW){1'b0}}, rd_data}),
    .shift(sck_fall & (ph_q == PH_READ)),
    .so(so)
  );

  assign so_oe   = oe_q;
  assign wr_stb  = stb_q;
  assign wr_chan = wrchan_q;
  assign wr_data = wdata_q;
  assign wr_nv   = wrnv_q;
  assign rd_req  = rdreq_q;
  assign rd_chan = rchan_q;
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       armed,
  input logic       held,
  input logic [2:0] bit_cnt,
  input logic       wp_n_s,
  input logic       wr_stb,
  input logic       wr_nv,
  input logic       rd_req,
  input logic       so_oe
);
  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r7_rdreq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r6_nv_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_nv) |-> $past(wp_n_s));

  a_r8_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(bit_cnt));

  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> !so_oe);

  a_r2_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!wr_stb && !rd_req));

  a_r3_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> !so_oe);
endmodule

bind spi_fe_top spi_fe_chk u_chk (
  .clk(clk), .rst_n(rst_ni), .cs_act(cs_act), .armed(armed_q), .held(held),
  .bit_cnt(bit_cnt), .wp_n_s(wp_n_s), .wr_stb(wr_stb), .wr_nv(wr_nv),
  .rd_req(rd_req), .so_oe(so_oe)
);

// File: tb/spi_fe_top_bench.sv
module spi_fe_top_bench;
  localparam int HALF = 10;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] ADDR = {6'b010100, STRAP};
  localparam logic [3:0] RD = 4'b1001, WV = 4'b1010, WNV = 4'b1100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sck, cs_n, si, hold_n, wp_n;
  logic so, so_oe, wr_stb, wr_nv, rd_req;
  logic [1:0] wr_chan, rd_chan;
  logic [5:0] wr_data, rd_data;
  logic [5:0] model [4];

  assign rd_data = model[rd_chan];

  spi_fe_top u_spi_fe_top (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .strap(STRAP), .so(so), .so_oe(so_oe),
    .wr_stb(wr_stb), .wr_chan(wr_chan), .wr_data(wr_data), .wr_nv(wr_nv),
    .rd_req(rd_req), .rd_chan(rd_chan), .rd_data(rd_data)
  );

  int n_chk = 0, n_err = 0, stb_cnt = 0, rdq_cnt = 0;
  logic [1:0] l_chan;
  logic [5:0] l_data;
  logic l_nv;
  bit done = 0;

  always @(posedge clk) begin
    if (wr_stb === 1'b1) begin
      stb_cnt++;
      l_chan = wr_chan;
      l_data = wr_data;
      l_nv = wr_nv;
    end
    if (rd_req === 1'b1) rdq_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // mode 1: pause while SCK low; 2: pause drops while SCK high; 3: pause lifts while SCK high
  task automatic xbit(input logic b, input int mode, output logic sob, output logic oeb);
    if (mode == 1) begin
      hold_n = 0; tick(HALF);
      chk(so_oe === 1'b0, "R8 so_oe during pause", so_oe, 0);
      repeat (3) begin si = ~si; sck = 1; tick(HALF); sck = 0; tick(HALF); end
      hold_n = 1; tick(HALF);
    end
    if (mode == 3) begin
      hold_n = 0; tick(HALF); sck = 1; tick(HALF);
      hold_n = 1; tick(HALF); sck = 0; tick(HALF);
    end
    si = b; tick(HALF);
    sob = so; oeb = so_oe;
    sck = 1; tick(HALF);
    if (mode == 2) begin
      hold_n = 0; tick(3); sck = 0; tick(HALF);
      chk(so_oe === 1'b0, "R9 so_oe after late pause", so_oe, 0);
      hold_n = 1; tick(HALF);
    end else begin
      sck = 0;
    end
  endtask

  task automatic xbyte(input logic [7:0] b, input int hbit, input int hmode,
                       output logic [7:0] got, output int oen);
    logic sb, ob;
    oen = 0;
    for (int i = 7; i >= 0; i--) begin
      xbit(b[i], (i == hbit) ? hmode : 0, sb, ob);
      got[i] = sb;
      if (ob === 1'b1) oen++;
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] ins, input logic [7:0] d,
                      input int nb, input int hbyte, input int hbit, input int hmode,
                      output logic [7:0] rdv, output int oetot);
    logic [7:0] g, bv;
    int oe;
    oetot = 0; rdv = '0;
    cs_n = 0; tick(HALF);
    for (int k = 0; k < nb; k++) begin
      bv = (k == 0) ? a : (k == 1) ? ins : (k == 2) ? d : 8'hA5;
      xbyte(bv, (k == hbyte) ? hbit : -1, hmode, g, oe);
      if (k == 2) rdv = g;
      oetot += oe;
    end
    tick(HALF); cs_n = 1; tick(2 * HALF);
  endtask

  task automatic run_case(input logic [7:0] a, input logic [7:0] ins, input logic [7:0] d,
                          input int nb, input int hbyte, input int hbit, input int hmode,
                          input string tag);
    bit aok, iok, exp_stb, exp_rd;
    logic [7:0] exp_rv, rdv;
    int s0, r0, oet;
    aok = (a == ADDR);                               // R1
    iok = (ins[3:2] == 2'b00);                       // R4
    exp_stb = nb >= 3 && aok && iok && d[7:6] == 2'b00 &&
              (ins[7:4] == WV || (ins[7:4] == WNV && wp_n));   // R5 R6
    exp_rd = nb >= 2 && aok && iok && ins[7:4] == RD;          // R7
    exp_rv = {2'b00, model[ins[1:0]]};
    s0 = stb_cnt; r0 = rdq_cnt;
    xfer(a, ins, d, nb, hbyte, hbit, hmode, rdv, oet);
    chk(stb_cnt - s0 == int'(exp_stb), {"R5 strobe count ", tag}, stb_cnt - s0, int'(exp_stb));
    if (exp_stb) begin
      chk(l_chan == ins[1:0] && l_data == d[5:0] && l_nv == (ins[7:4] == WNV),
          {"R5 strobe fields ", tag}, {l_nv, l_chan, l_data}, {ins[7:4] == WNV, ins[1:0], d[5:0]});
      model[ins[1:0]] = d[5:0];
    end
    chk(rdq_cnt - r0 == int'(exp_rd), {"R7 read requests ", tag}, rdq_cnt - r0, int'(exp_rd));
    if (exp_rd && nb >= 3)
      chk(rdv == exp_rv, {"R7 read value ", tag}, rdv, exp_rv);
    chk(oet == ((exp_rd && nb >= 3) ? 8 : 0), {"R7 so_oe window ", tag}, oet,
        (exp_rd && nb >= 3) ? 8 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] g, a, ins, d;
    logic sb, ob;
    int oe, s0, nb, hb;
    for (int i = 0; i < 4; i++) model[i] = '0;
    void'($urandom(32'd20240611));
    rst_n = 0; sck = 0; cs_n = 0; si = 0; hold_n = 1; wp_n = 1;
    tick(10);
    rst_n = 1;
    tick(6);
    // R3 R2: reset state
    chk(so_oe === 1'b0, "R3 reset so_oe", so_oe, 0);
    chk(wr_stb === 1'b0 && rd_req === 1'b0, "R2 reset strobes", wr_stb, 0);

    // R2: chip select low since reset, no falling edge seen yet
    s0 = stb_cnt;
    xbyte(ADDR, -1, 0, g, oe);
    xbyte({WV, 2'b00, 2'd1}, -1, 0, g, oe);
    xbyte(8'h15, -1, 0, g, oe);
    tick(HALF);
    chk(stb_cnt == s0, "R2 unarmed write ignored", stb_cnt - s0, 0);
    cs_n = 1; tick(2 * HALF);

    // R5 R7: basic write then read back
    run_case(ADDR, {WV, 2'b00, 2'd2}, 8'h2A, 3, -1, -1, 0, "wr ch2");
    run_case(ADDR, {RD, 2'b00, 2'd2}, 8'h00, 3, -1, -1, 0, "rd ch2");
    // R5: fourth byte ignored
    run_case(ADDR, {WV, 2'b00, 2'd0}, 8'h31, 4, -1, -1, 0, "extra byte");
    run_case(ADDR, {RD, 2'b00, 2'd0}, 8'h00, 4, -1, -1, 0, "rd extra byte");
    // R8: pause in data byte and in returned byte
    run_case(ADDR, {WV, 2'b00, 2'd3}, 8'h1B, 3, 2, 3, 1, "R8 pause write");
    run_case(ADDR, {RD, 2'b00, 2'd3}, 8'h00, 3, 2, 4, 1, "R8 pause read");
    // R9: pause edges while SCK high inside the returned byte
    run_case(ADDR, {WV, 2'b00, 2'd1}, 8'h2D, 3, -1, -1, 0, "wr ch1");
    run_case(ADDR, {RD, 2'b00, 2'd1}, 8'h00, 3, 2, 5, 2, "R9 late drop");
    run_case(ADDR, {RD, 2'b00, 2'd1}, 8'h00, 3, 2, 2, 3, "R9 late lift");

    // R3: chip select rises in the middle of the data byte
    s0 = stb_cnt;
    cs_n = 0; tick(HALF);
    xbyte(ADDR, -1, 0, g, oe);
    xbyte({WV, 2'b00, 2'd0}, -1, 0, g, oe);
    for (int i = 0; i < 4; i++) xbit(1'b1, 0, sb, ob);
    tick(HALF); cs_n = 1; tick(2 * HALF);
    chk(stb_cnt == s0, "R3 partial byte no strobe", stb_cnt - s0, 0);
    run_case(ADDR, {WV, 2'b00, 2'd0}, 8'h0C, 3, -1, -1, 0, "R3 after abort");

    // R6: write protect
    wp_n = 0;
    run_case(ADDR, {WNV, 2'b00, 2'd2}, 8'h3F, 3, -1, -1, 0, "R6 nv blocked");
    run_case(ADDR, {WV, 2'b00, 2'd2}, 8'h11, 3, -1, -1, 0, "R6 volatile ok");
    wp_n = 1;
    run_case(ADDR, {WNV, 2'b00, 2'd2}, 8'h3E, 3, -1, -1, 0, "R6 nv allowed");

    // R1: address mismatches
    run_case({6'b011100, STRAP}, {WV, 2'b00, 2'd1}, 8'h05, 3, -1, -1, 0, "R1 upper bits");
    run_case({6'b010100, ~STRAP}, {RD, 2'b00, 2'd1}, 8'h00, 3, -1, -1, 0, "R1 strap");
    // R4: reserved bits and unknown opcode
    run_case(ADDR, {WV, 2'b01, 2'd1}, 8'h06, 3, -1, -1, 0, "R4 reserved");
    run_case(ADDR, {4'b0110, 2'b00, 2'd1}, 8'h07, 3, -1, -1, 0, "R4 unknown op");
    // R5: data byte with upper bits set
    run_case(ADDR, {WV, 2'b00, 2'd1}, 8'hC9, 3, -1, -1, 0, "R5 bad data");

    // random mix
    for (int t = 0; t < 40; t++) begin
      a = ($urandom % 4 == 0) ? 8'($urandom) : ADDR;
      case ($urandom % 4)
        0: ins[7:4] = RD;
        1: ins[7:4] = WV;
        2: ins[7:4] = WNV;
        default: ins[7:4] = 4'($urandom);
      endcase
      ins[3:2] = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
      ins[1:0] = 2'($urandom);
      d = ($urandom % 5 == 0) ? 8'($urandom) : {2'b00, 6'($urandom)};
      nb = 2 + int'($urandom % 3);
      wp_n = 1'($urandom);
      hb = int'($urandom % 5);
      run_case(a, ins, d, nb, hb, int'($urandom % 8), 1 + int'($urandom % 3), "random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule